// File: doc/BRIEF.md
# Master Clock Enable Generator

This block derives a slower system clock enable from a fast reference clock. Four source clock-enable strobes arrive at reference rate. A small configuration register picks one of them and applies a prescaler and then a post-divider, so the block emits one output enable pulse for every N strobes of the chosen source. N is the prescaler value times the post-divider value. The applied ratio is shown on an output. Two flags report when that ratio lies outside a range fixed at build time. A ready bit tells software when the output has settled after a change.

The register is read and written through a plain synchronous bus. A build-time layout parameter sets where the prescaler field sits and which register bits exist. Layout 0 puts the prescaler at bits 4:2 and keeps bits 0x31F. Layout 1 puts it at bits 6:4 and keeps bits 0x373. The source select stays at bits 1:0 and the post-divider index stays at bits 9:8 in both layouts. A new setting is never applied in the middle of an output period. It is held until the running period ends, so no short period is produced.

Top module: `mck_gen`

## Requirements
- R1: After reset the register reads 0, which means source 0, prescaler code 0 (divide by 1) and divider index 0. total_ratio then shows the table entry at index 0, which is 1 for the bench build, and mck_ready stays low until the first output pulse.
- R2: Register bits 1:0 select which src_en bit is counted. Source k is bit k.
- R3: The 3-bit prescaler code c divides the selected strobes by 2^c. The code sits at bits 6:4 when LAYOUT=1 and at bits 4:2 when LAYOUT=0.
- R4: When DIV3_EN is 1, prescaler code 7 divides by 3 instead of 128.
- R5: Register bits 9:8 index a 4-entry divisor table, where entry k sits at DIV_TABLE[k*DIV_W +: DIV_W]. total_ratio equals the prescaler value times the table entry. mck_en goes high one cycle after every total_ratio-th selected strobe.
- R6: A table entry of 0 acts as a divisor of 1.
- R7: Register bits outside the layout mask read 0 and ignore writes. For LAYOUT=1, writing 0x3FF reads back 0x373.
- R8: A write that changes any implemented bit clears mck_ready in the next cycle. A write of the value already held leaves mck_ready unchanged.
- R9: After a changing write, mck_ready rises together with the third output pulse. The first of these pulses ends the old period and applies the new setting; the next two complete full periods under the new setting.
- R10: A new setting takes effect only at the next output pulse. The period running at the time of the write keeps its old length, and total_ratio changes only in a cycle where mck_en is high.
- R11: overclk is high when total_ratio < MIN_RATIO, and underclk is high when total_ratio > MAX_RATIO.
- R12: mck_en is high for a single reference cycle whenever the next selected strobe does not also complete a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 4 | Source clock-enable strobes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 10 | Register write data |
| rd_data | output | 10 | Register read data |
| mck_en | output | 1 | Output clock-enable pulse |
| mck_ready | output | 1 | Output settled after the last change |
| total_ratio | output | 8+DIV_W | Applied total divide ratio |
| underclk | output | 1 | Ratio above MAX_RATIO |
| overclk | output | 1 | Ratio below MIN_RATIO |

## Verification
The bench builds the block with layout 1, the divide-by-3 option on, a divisor table of 1, 2, 3 and 0, and an allowed ratio range of 2 to 64. With these values the masked bits, prescaler code 7 read as divide-by-3, and the zero table entry can all be observed. Both range flags can be raised, overclk with a ratio of 1 and underclk with a ratio of 128. The bench drives source strobes with periods of 1 to 4 cycles, so each output period is the ratio times the source period. This lets the select field be checked at the same time as the divide chain.

// File: rtl/mck_pkg.sv
`timescale 1ns/1ps
package mck_pkg;
  localparam int CFG_W = 10;
  localparam int NSRC  = 4;
  localparam int PRE_W = 8;

  typedef struct packed {
    logic [1:0] div;
    logic [2:0] pres;
    logic [1:0] sel;
  } mck_cfg_t;

  function automatic logic [CFG_W-1:0] impl_mask(input int layout);
    return (layout == 0) ? 10'h31F : 10'h373;
  endfunction

  function automatic int pres_lsb(input int layout);
    return (layout == 0) ? 2 : 4;
  endfunction
endpackage

// File: rtl/mck_cfg_reg.sv
`timescale 1ns/1ps
module mck_cfg_reg import mck_pkg::*; #(
  parameter int LAYOUT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output mck_cfg_t         cfg,
  output logic             cfg_chg
);
  localparam logic [CFG_W-1:0] MASK = impl_mask(LAYOUT);
  localparam int PL = pres_lsb(LAYOUT);

  logic [CFG_W-1:0] reg_q, reg_d, wr_m;

  always_comb begin
    wr_m    = wr_data & MASK;
    reg_d   = reg_q;
    cfg_chg = 1'b0;
    if (wr_en) begin
      reg_d   = wr_m;
      cfg_chg = (wr_m != reg_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  assign rd_data  = reg_q;
  assign cfg.sel  = reg_q[1:0];
  assign cfg.pres = reg_q[PL+2:PL];
  assign cfg.div  = reg_q[9:8];
endmodule

// File: rtl/mck_ratio.sv
`timescale 1ns/1ps
module mck_ratio import mck_pkg::*; #(
  parameter int DIV3_EN = 1,
  parameter int DIV_W = 8,
  parameter logic [4*DIV_W-1:0] DIV_TABLE = {8'd4, 8'd3, 8'd2, 8'd1},
  parameter int MIN_RATIO = 1,
  parameter int MAX_RATIO = 1024
) (
  input  mck_cfg_t                 cfg,
  output logic [PRE_W-1:0]         pre_div,
  output logic [DIV_W-1:0]         post_div,
  output logic [PRE_W+DIV_W-1:0]   ratio,
  output logic                     under,
  output logic                     over
);
  localparam int RW = PRE_W + DIV_W;

  logic [DIV_W-1:0] tbl [4];

  for (genvar g = 0; g < 4; g++) begin : g_tbl
    localparam logic [DIV_W-1:0] RAW = DIV_TABLE[g*DIV_W +: DIV_W];
    assign tbl[g] = (RAW == '0) ? DIV_W'(1) : RAW;
  end

  always_comb begin
    if (DIV3_EN != 0 && cfg.pres == 3'd7) pre_div = PRE_W'(3);
    else                                  pre_div = PRE_W'(1) << cfg.pres;
    post_div = tbl[cfg.div];
    ratio    = RW'(pre_div) * RW'(post_div);
    over     = ratio < RW'(MIN_RATIO);
    under    = ratio > RW'(MAX_RATIO);
  end
endmodule

// File: rtl/mck_div_chain.sv
`timescale 1ns/1ps
module mck_div_chain import mck_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [DIV_W-1:0] post_div,
  output logic             fire
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] post_q, post_d;
  logic pre_wrap, post_wrap;

  always_comb begin
    pre_wrap  = (pre_q == pre_div - PRE_W'(1));
    post_wrap = (post_q == post_div - DIV_W'(1));
    pre_d  = pre_q;
    post_d = post_q;
    if (strobe) begin
      if (pre_wrap) begin
        pre_d  = '0;
        post_d = post_wrap ? '0 : post_q + DIV_W'(1);
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
    fire = strobe & pre_wrap & post_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      post_q <= '0;
    end else begin
      pre_q  <= pre_d;
      post_q <= post_d;
    end
  end
endmodule

// File: rtl/mck_gen.sv
`timescale 1ns/1ps
module mck_gen import mck_pkg::*; #(
  parameter int LAYOUT = 0,
  parameter int DIV3_EN = 1,
  parameter int DIV_W = 8,
  parameter logic [4*DIV_W-1:0] DIV_TABLE = {8'd4, 8'd3, 8'd2, 8'd1},
  parameter int MIN_RATIO = 1,
  parameter int MAX_RATIO = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             src_en,
  input  logic                   wr_en,
  input  logic [9:0]             wr_data,
  output logic [9:0]             rd_data,
  output logic                   mck_en,
  output logic                   mck_ready,
  output logic [8+DIV_W-1:0]     total_ratio,
  output logic                   underclk,
  output logic                   overclk
);
  localparam logic [1:0] RDY_DONE = 2'd3;
  localparam logic [1:0] RDY_BOOT = 2'd2;

  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  mck_cfg_t cfg_w, act_q, act_d;
  logic     cfg_chg, fire, strobe, mck_en_q;
  logic [1:0] rdy_q, rdy_d;
  logic [PRE_W-1:0] pre_div;
  logic [DIV_W-1:0] post_div;

  mck_cfg_reg #(.LAYOUT(LAYOUT)) u_reg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cfg(cfg_w), .cfg_chg(cfg_chg)
  );

  mck_ratio #(
    .DIV3_EN(DIV3_EN), .DIV_W(DIV_W), .DIV_TABLE(DIV_TABLE),
    .MIN_RATIO(MIN_RATIO), .MAX_RATIO(MAX_RATIO)
  ) u_ratio (
    .cfg(act_q), .pre_div(pre_div), .post_div(post_div),
    .ratio(total_ratio), .under(underclk), .over(overclk)
  );

  assign strobe = src_en[act_q.sel];

  mck_div_chain #(.DIV_W(DIV_W)) u_chain (
    .clk(clk), .rst_n(rst_int_n), .strobe(strobe),
    .pre_div(pre_div), .post_div(post_div), .fire(fire)
  );

  always_comb begin
    act_d = fire ? cfg_w : act_q;
    rdy_d = rdy_q;
    if (cfg_chg)                     rdy_d = '0;
    else if (fire && rdy_q != RDY_DONE) rdy_d = rdy_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      act_q    <= '0;
      rdy_q    <= RDY_BOOT;
      mck_en_q <= 1'b0;
    end else begin
      act_q    <= act_d;
      rdy_q    <= rdy_d;
      mck_en_q <= fire;
    end
  end

  assign mck_en    = mck_en_q;
  assign mck_ready = (rdy_q == RDY_DONE);
endmodule

// File: rtl/mck_gen_chk.sv
`timescale 1ns/1ps
module mck_gen_chk import mck_pkg::*; #(
  parameter int LAYOUT = 0,
  parameter int RATIO_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [9:0]         wr_data,
  input logic [9:0]         rd_data,
  input logic               mck_en,
  input logic               mck_ready,
  input logic [RATIO_W-1:0] total_ratio,
  input logic               underclk,
  input logic               overclk
);
  localparam logic [9:0] MASK = impl_mask(LAYOUT);

  assert_rdy_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_data & MASK) != rd_data)) |=> !mck_ready);

  assert_rdy_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mck_ready) |-> mck_en);

  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~MASK) == '0);

  assert_ratio_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(total_ratio) |-> mck_en);

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(underclk && overclk));
endmodule

bind mck_gen mck_gen_chk #(.LAYOUT(LAYOUT), .RATIO_W(8+DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .mck_en(mck_en), .mck_ready(mck_ready),
  .total_ratio(total_ratio), .underclk(underclk), .overclk(overclk)
);

// File: tb/sim_mck_gen.sv
`timescale 1ns/1ps
module sim_mck_gen;
  logic clk, rst_n, wr_en, mck_en, mck_ready, underclk, overclk;
  logic [3:0]  src_en;
  logic [9:0]  wr_data, rd_data;
  logic [15:0] total_ratio;
  int n_chk = 0;
  int n_err = 0;
  int phase = 0;

  mck_gen #(
    .LAYOUT(1), .DIV3_EN(1), .DIV_W(8),
    .DIV_TABLE({8'd0, 8'd3, 8'd2, 8'd1}),
    .MIN_RATIO(2), .MAX_RATIO(64)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .mck_en(mck_en),
    .mck_ready(mck_ready), .total_ratio(total_ratio),
    .underclk(underclk), .overclk(overclk)
  );

  typedef struct packed {
    logic [9:0]  cfg;
    logic [15:0] ratio;
    logic [15:0] period;
    logic        under;
    logic        over;
  } vec_t;

  // cfg = div<<8 | pres<<4 | sel ; period = ratio * (sel+1)
  localparam vec_t VECS [7] = '{
    '{10'h000, 16'd1,   16'd1,   1'b0, 1'b1},
    '{10'h120, 16'd8,   16'd8,   1'b0, 1'b0},
    '{10'h211, 16'd6,   16'd12,  1'b0, 1'b0},
    '{10'h072, 16'd3,   16'd9,   1'b0, 1'b0},
    '{10'h303, 16'd1,   16'd4,   1'b0, 1'b1},
    '{10'h160, 16'd128, 16'd128, 1'b1, 1'b0},
    '{10'h233, 16'd24,  16'd96,  1'b0, 1'b0}
  };

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // source k strobes every k+1 cycles
  initial begin
    src_en = 4'hF;
    forever begin
      @(negedge clk);
      phase = phase + 1;
      for (int k = 0; k < 4; k++) src_en[k] = ((phase % (k + 1)) == 0);
    end
  end

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not end, actual=running expected=done");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse();
    while (!mck_en) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    wait_pulse();
    do begin @(negedge clk); n++; end while (!mck_en);
  endtask

  task automatic wait_ready();
    while (!mck_ready) @(negedge clk);
  endtask

  initial begin
    int n, p;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rd_data == 10'h000, "R1 rd_data", rd_data, 0);
    chk(total_ratio == 16'd1, "R1 ratio", total_ratio, 1);
    chk(!mck_ready, "R1 ready low", mck_ready, 0);
    wait_pulse();
    chk(mck_ready, "R1 ready at first pulse", mck_ready, 1);

    // R2 R3 R4 R5 R6 R11: vector walk
    for (int i = 0; i < 7; i++) begin
      wait_pulse();
      wr(VECS[i].cfg);
      wait_ready();
      measure(p);
      chk(total_ratio == VECS[i].ratio, "R5 ratio", total_ratio, VECS[i].ratio);
      chk(p == int'(VECS[i].period), "R2/R3/R4/R6 period", p, VECS[i].period);
      chk(underclk == VECS[i].under, "R11 under", underclk, VECS[i].under);
      chk(overclk == VECS[i].over, "R11 over", overclk, VECS[i].over);
    end

    // R12: single-cycle pulse (ratio 24 on a 4-cycle source)
    wait_pulse();
    @(negedge clk);
    chk(!mck_en, "R12 pulse width", mck_en, 0);

    // R8 + R9: changing write clears ready, ready returns with third pulse
    wait_pulse();
    wr(10'h120);
    chk(!mck_ready, "R8 ready cleared", mck_ready, 0);
    n = 0;
    while (!mck_ready) begin
      @(negedge clk);
      if (mck_en) n++;
    end
    chk(n == 3, "R9 pulses to ready", n, 3);
    chk(mck_en, "R9 ready with pulse", mck_en, 1);

    // R10: deferred application
    wait_pulse();
    wr(10'h233);
    chk(total_ratio == 16'd8, "R10 ratio held", total_ratio, 8);
    chk(rd_data == 10'h233, "R10 reg written", rd_data, 10'h233);
    n = 1;
    while (!mck_en) begin @(negedge clk); n++; end
    chk(n == 8, "R10 old period kept", n, 8);
    chk(total_ratio == 16'd24, "R10 ratio at boundary", total_ratio, 24);

    // R8: identical write keeps ready
    wait_ready();
    @(negedge clk);
    wr(10'h233);
    chk(mck_ready, "R8 identical write", mck_ready, 1);

    // R7: unimplemented bits
    wr(10'h3FF);
    chk(rd_data == 10'h373, "R7 mask", rd_data, 10'h373);
    chk(!mck_ready, "R8 masked write changes", mck_ready, 0);

    summary();
    $finish;
  end
endmodule